// File: doc/BRIEF.md
# Sync Polarity and Frequency Monitor

This block watches an asynchronous horizontal sync line and an asynchronous vertical sync line and reports several facts about each one. It reports the polarity, whether the line is toggling at all, and the line's resting level. It also notices composite sync carried on the horizontal line and classifies the overall input situation as one of four modes. Both inputs are resynchronised, and edge detection runs before any other logic uses them.

On a start pulse for one axis, the block measures that axis's period. It waits for the next rising edge, then counts reference units over a fixed number of periods: 64 lines for the horizontal axis and 4 frames for the vertical axis. When the window closes it holds the result and raises a finished flag. A reference unit is 16 ticks of a 4 MHz reference for the horizontal axis and 1024 ticks for the vertical axis. A 2-bit force field per axis can override the reported polarity.

Top module: `sync_monitor`

## Requirements
- R1: After `h_start`, from the next rising edge of the synchronised horizontal input over the following 64 rising edges (H_SPAN), `h_count` = floor(window clocks / (REF_DIV*H_UNIT)). With the defaults this is the number of 250 kHz units in 64 lines; for example, 15.7 kHz gives 1019.
- R2: The same rule applies to the vertical axis over 4 frames (V_SPAN), with unit REF_DIV*V_UNIT and a 9-bit `v_count`. With the defaults, 60 Hz gives 260.
- R3: A start pulse drops that axis's done flag on the next cycle and begins a new measurement. Done rises only when the window has closed. While done is high and no start arrives, done and the count stay unchanged.
- R4: A count that would pass all-ones holds at all-ones (2047 horizontal, 511 vertical). Done is still set when the window closes.
- R5: Any edge on a synchronised input sets its present bit on the next cycle. The bit clears after H_TMO (horizontal) or V_TMO (vertical) clocks without an edge.
- R6: `mode` is 2'b00 when both inputs are present, 2'b01 when only horizontal is present, 2'b10 when only vertical is present, and 2'b11 when neither is present.
- R7: With force 2'b00, the reported polarity is 1 (positive) when the high phase of the period is shorter than the low phase, and 0 otherwise.
- R8: Force 2'b01 reports polarity 1. Force 2'b10 reports 0. Force 2'b11 behaves like 2'b00 (auto-detection).
- R9: `h_lvl` and `v_lvl` follow the synchronised input level. They carry meaning while the matching present bit is 0.
- R10: A horizontal phase of more than H_LONG clocks while the line is present sets `hv_pre`. `hv_pre` clears after COMP_TMO clocks without such a phase. A phase of H_LONG clocks or more leaves the polarity unchanged.
- R11: After reset, both done flags and counts are 0, the present bits and `hv_pre` are 0, and `mode` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, REF_DIV cycles per 4 MHz tick |
| rst | input | 1 | Synchronous active-high reset |
| hs_in | input | 1 | Asynchronous horizontal (or composite) sync |
| vs_in | input | 1 | Asynchronous vertical sync |
| h_start | input | 1 | One-cycle pulse starting a horizontal measurement |
| v_start | input | 1 | One-cycle pulse starting a vertical measurement |
| h_force | input | 2 | Horizontal polarity override (01 = 1, 10 = 0, other = auto) |
| v_force | input | 2 | Vertical polarity override |
| h_pol | output | 1 | Horizontal polarity, 1 = positive |
| v_pol | output | 1 | Vertical polarity |
| h_pre | output | 1 | Horizontal input present |
| v_pre | output | 1 | Vertical input present |
| hv_pre | output | 1 | Composite sync seen on the horizontal input |
| h_lvl | output | 1 | Synchronised horizontal level |
| v_lvl | output | 1 | Synchronised vertical level |
| mode | output | 2 | Input mode code |
| h_count | output | H_W | Horizontal period result |
| h_done | output | 1 | Horizontal result valid |
| v_count | output | V_W | Vertical period result |
| v_done | output | 1 | Vertical result valid |

## Verification
The assertions check on every cycle that a start pulse drops done and that a finished result holds still. They also check that a count never moves backwards between starts, so it cannot wrap. Finally, they check that an edge always marks its input present and that loss of presence occurs only after a quiet cycle. The bench scenarios cover the rest: the exact count values for several line and frame periods, saturation, the mode codes, polarity auto-detection and overrides, the composite flag appearing and timing out, and the resting level reported once an input goes quiet.

// File: rtl/syncmon_pkg.sv
package syncmon_pkg;

  typedef enum logic [1:0] {
    MODE_SEP  = 2'b00,
    MODE_COMP = 2'b01,
    MODE_SUSP = 2'b10,
    MODE_OFF  = 2'b11
  } sync_mode_e;

  function automatic logic pick_pol(input logic [1:0] frc, input logic auto_pol);
    case (frc)
      2'b01:   return 1'b1;
      2'b10:   return 1'b0;
      default: return auto_pol;
    endcase
  endfunction

  function automatic sync_mode_e decode_mode(input logic hp, input logic vp);
    case ({hp, vp})
      2'b11:   return MODE_SEP;
      2'b10:   return MODE_COMP;
      2'b01:   return MODE_SUSP;
      default: return MODE_OFF;
    endcase
  endfunction

endpackage

// File: rtl/syncmon_input.sv
module syncmon_input #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign lvl  = sh[STAGES-1];
  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/syncmon_phase.sv
// Presence timeout and high/low phase comparison for one sync line.
module syncmon_phase #(
  parameter int TMO  = 8000,
  parameter int LONG = 600,
  parameter int PW_W = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic rise,
  input  logic fall,
  output logic present,
  output logic pol_auto
);
  localparam int TW = $clog2(TMO + 1);
  localparam logic [TW-1:0]   TMO_END = TW'(TMO - 1);
  localparam logic [PW_W-1:0] PW_MAX  = '1;
  localparam logic [PW_W-1:0] LONG_V  = PW_W'(LONG);

  logic [TW-1:0]   quiet;
  logic [PW_W-1:0] hi_cnt, lo_cnt, hi_len, lo_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet   <= '0;
      present <= 1'b0;
    end else if (rise | fall) begin
      quiet   <= '0;
      present <= 1'b1;
    end else if (quiet == TMO_END) begin
      present <= 1'b0;
    end else begin
      quiet <= quiet + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= '0;
      lo_cnt   <= '0;
      hi_len   <= '0;
      lo_len   <= '0;
      pol_auto <= 1'b0;
    end else begin
      if (rise) begin
        lo_len <= lo_cnt;
        hi_cnt <= PW_W'(1);
        if (lo_cnt < LONG_V && hi_len < LONG_V) pol_auto <= (hi_len < lo_cnt);
      end else if (lvl && hi_cnt != PW_MAX) begin
        hi_cnt <= hi_cnt + 1'b1;
      end
      if (fall) begin
        hi_len <= hi_cnt;
        lo_cnt <= PW_W'(1);
        if (hi_cnt < LONG_V && lo_len < LONG_V) pol_auto <= (hi_cnt < lo_len);
      end else if (!lvl && lo_cnt != PW_MAX) begin
        lo_cnt <= lo_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/syncmon_period.sv
// Counts units of UNIT_CLK clocks across SPAN periods of one sync line.
module syncmon_period #(
  parameter int UNIT_CLK = 32,
  parameter int SPAN     = 64,
  parameter int W        = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         rise,
  output logic [W-1:0] count,
  output logic         done
);
  localparam int PCW = (UNIT_CLK > 1) ? $clog2(UNIT_CLK) : 1;
  localparam int EW  = (SPAN > 1) ? $clog2(SPAN) : 1;
  localparam logic [PCW-1:0] PRE_END  = PCW'(UNIT_CLK - 1);
  localparam logic [EW-1:0]  SPAN_END = EW'(SPAN - 1);
  localparam logic [W-1:0]   CNT_MAX  = '1;

  logic           armed, busy;
  logic [PCW-1:0] pre;
  logic [EW-1:0]  edges;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
      pre   <= '0;
      edges <= '0;
      count <= '0;
    end else if (start) begin
      armed <= 1'b1;
      busy  <= 1'b0;
      done  <= 1'b0;
      count <= '0;
    end else if (armed && rise) begin
      armed <= 1'b0;
      busy  <= 1'b1;
      pre   <= '0;
      edges <= '0;
    end else if (busy) begin
      if (pre == PRE_END) begin
        pre <= '0;
        if (count != CNT_MAX) count <= count + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
      if (rise) begin
        if (edges == SPAN_END) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          edges <= edges + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/syncmon_wide.sv
// Flags composite sync: an over-long phase on a present horizontal line.
module syncmon_wide #(
  parameter int LONG = 600,
  parameter int TMO  = 800000
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_in,
  input  logic present,
  output logic seen
);
  localparam int GW = $clog2(LONG + 1);
  localparam int TW = $clog2(TMO + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(LONG);
  localparam logic [TW-1:0] TMO_END = TW'(TMO - 1);

  logic [GW-1:0] gap;
  logic [TW-1:0] hold;
  logic          long_edge;

  assign long_edge = edge_in && present && (gap == GAP_MAX);

  always_ff @(posedge clk) begin
    if (rst)                  gap <= '0;
    else if (edge_in)         gap <= '0;
    else if (gap != GAP_MAX)  gap <= gap + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 1'b0;
      hold <= '0;
    end else if (long_edge) begin
      seen <= 1'b1;
      hold <= '0;
    end else if (seen) begin
      if (hold == TMO_END) seen <= 1'b0;
      else                 hold <= hold + 1'b1;
    end
  end
endmodule

// File: rtl/sync_monitor.sv
module sync_monitor #(
  parameter int REF_DIV     = 2,
  parameter int H_UNIT      = 16,
  parameter int V_UNIT      = 1024,
  parameter int H_SPAN      = 64,
  parameter int V_SPAN      = 4,
  parameter int H_W         = 11,
  parameter int V_W         = 9,
  parameter int H_TMO       = 8000,
  parameter int V_TMO       = 800000,
  parameter int H_LONG      = 600,
  parameter int COMP_TMO    = 800000,
  parameter int PW_W        = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hs_in,
  input  logic           vs_in,
  input  logic           h_start,
  input  logic           v_start,
  input  logic [1:0]     h_force,
  input  logic [1:0]     v_force,
  output logic           h_pol,
  output logic           v_pol,
  output logic           h_pre,
  output logic           v_pre,
  output logic           hv_pre,
  output logic           h_lvl,
  output logic           v_lvl,
  output logic [1:0]     mode,
  output logic [H_W-1:0] h_count,
  output logic           h_done,
  output logic [V_W-1:0] v_count,
  output logic           v_done
);
  import syncmon_pkg::*;

  localparam int H_UNIT_CLK = REF_DIV * H_UNIT;
  localparam int V_UNIT_CLK = REF_DIV * V_UNIT;
  localparam int V_LONG     = (1 << PW_W) - 1;

  logic h_rise, h_fall, v_rise, v_fall;
  logic h_auto, v_auto, h_comp;

  syncmon_input #(.STAGES(SYNC_STAGES)) u_h_in (
    .clk(clk), .rst(rst), .din(hs_in), .lvl(h_lvl), .rise(h_rise), .fall(h_fall));
  syncmon_input #(.STAGES(SYNC_STAGES)) u_v_in (
    .clk(clk), .rst(rst), .din(vs_in), .lvl(v_lvl), .rise(v_rise), .fall(v_fall));

  syncmon_phase #(.TMO(H_TMO), .LONG(H_LONG), .PW_W(PW_W)) u_h_ph (
    .clk(clk), .rst(rst), .lvl(h_lvl), .rise(h_rise), .fall(h_fall),
    .present(h_pre), .pol_auto(h_auto));
  syncmon_phase #(.TMO(V_TMO), .LONG(V_LONG), .PW_W(PW_W)) u_v_ph (
    .clk(clk), .rst(rst), .lvl(v_lvl), .rise(v_rise), .fall(v_fall),
    .present(v_pre), .pol_auto(v_auto));

  syncmon_wide #(.LONG(H_LONG), .TMO(COMP_TMO)) u_h_wide (
    .clk(clk), .rst(rst), .edge_in(h_rise | h_fall), .present(h_pre), .seen(h_comp));

  syncmon_period #(.UNIT_CLK(H_UNIT_CLK), .SPAN(H_SPAN), .W(H_W)) u_h_per (
    .clk(clk), .rst(rst), .start(h_start), .rise(h_rise), .count(h_count), .done(h_done));
  syncmon_period #(.UNIT_CLK(V_UNIT_CLK), .SPAN(V_SPAN), .W(V_W)) u_v_per (
    .clk(clk), .rst(rst), .start(v_start), .rise(v_rise), .count(v_count), .done(v_done));

  always_ff @(posedge clk) begin
    if (rst) begin
      h_pol  <= 1'b0;
      v_pol  <= 1'b0;
      hv_pre <= 1'b0;
      mode   <= MODE_OFF;
    end else begin
      h_pol  <= pick_pol(h_force, h_auto);
      v_pol  <= pick_pol(v_force, v_auto);
      hv_pre <= h_comp & h_pre;
      mode   <= decode_mode(h_pre, v_pre);
    end
  end
endmodule

// File: rtl/sync_monitor_chk.sv
module sync_monitor_chk #(
  parameter int H_W = 11,
  parameter int V_W = 9
) (
  input logic           clk,
  input logic           rst,
  input logic           h_lvl,
  input logic           v_lvl,
  input logic           h_pre,
  input logic           v_pre,
  input logic           h_start,
  input logic           v_start,
  input logic           h_done,
  input logic           v_done,
  input logic [H_W-1:0] h_count,
  input logic [V_W-1:0] v_count
);
  p_start_clears_h_r3: assert property (@(posedge clk) disable iff (rst)
    h_start |=> !h_done);
  p_start_clears_v_r3: assert property (@(posedge clk) disable iff (rst)
    v_start |=> !v_done);
  p_done_holds_h_r3: assert property (@(posedge clk) disable iff (rst)
    (h_done && !h_start) |=> (h_done && $stable(h_count)));
  p_done_holds_v_r3: assert property (@(posedge clk) disable iff (rst)
    (v_done && !v_start) |=> (v_done && $stable(v_count)));
  p_no_wrap_h_r4: assert property (@(posedge clk) disable iff (rst)
    !h_start |=> (h_count >= $past(h_count)));
  p_no_wrap_v_r4: assert property (@(posedge clk) disable iff (rst)
    !v_start |=> (v_count >= $past(v_count)));
  p_edge_present_h_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(h_lvl) |=> h_pre);
  p_edge_present_v_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(v_lvl) |=> v_pre);
  p_loss_quiet_h_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(h_pre) |-> ($past(h_lvl) == $past(h_lvl, 2)));
  p_loss_quiet_v_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(v_pre) |-> ($past(v_lvl) == $past(v_lvl, 2)));
endmodule

bind sync_monitor sync_monitor_chk #(.H_W(H_W), .V_W(V_W)) u_chk (
  .clk(clk), .rst(rst), .h_lvl(h_lvl), .v_lvl(v_lvl), .h_pre(h_pre), .v_pre(v_pre),
  .h_start(h_start), .v_start(v_start), .h_done(h_done), .v_done(v_done),
  .h_count(h_count), .v_count(v_count));

// File: tb/test_sync_monitor.sv
`timescale 1ns/1ps
module test_sync_monitor;
  localparam int H_TMO = 300, V_TMO = 6000, H_LONG = 100, COMP_TMO = 4000;

  logic clk = 1'b0, rst = 1'b1;
  logic hs = 1'b0, vs = 1'b0, h_start = 1'b0, v_start = 1'b0;
  logic [1:0] h_force = 2'b00, v_force = 2'b00;
  logic h_pol, v_pol, h_pre, v_pre, hv_pre, h_lvl, v_lvl, h_done, v_done;
  logic [1:0] mode;
  logic [10:0] h_count;
  logic [8:0] v_count;

  int checks = 0, errors = 0, cycles = 0;
  int hp = 40, hw = 4, vp = 800, vw = 20;
  bit hneg = 0, vneg = 0, hen = 0, ven = 0, hidle = 0, vidle = 0, hwide = 0;

  always #2.5 clk = ~clk;

  sync_monitor #(.REF_DIV(1), .H_UNIT(4), .V_UNIT(16), .H_TMO(H_TMO), .V_TMO(V_TMO),
    .H_LONG(H_LONG), .COMP_TMO(COMP_TMO)) i_sync_monitor (
    .clk(clk), .rst(rst), .hs_in(hs), .vs_in(vs), .h_start(h_start), .v_start(v_start),
    .h_force(h_force), .v_force(v_force), .h_pol(h_pol), .v_pol(v_pol), .h_pre(h_pre),
    .v_pre(v_pre), .hv_pre(hv_pre), .h_lvl(h_lvl), .v_lvl(v_lvl), .mode(mode),
    .h_count(h_count), .h_done(h_done), .v_count(v_count), .v_done(v_done));

  // columns: h period, h pulse, h negative, v period, v pulse, v negative, exp h, exp v
  localparam int ROWS = 4;
  localparam int TBL [ROWS][8] = '{
    '{40, 4, 0,  800, 20, 0,  640, 200},
    '{52, 6, 1, 1000, 30, 1,  832, 250},
    '{31, 3, 0,  613, 11, 1,  496, 153},
    '{99, 5, 1, 2041, 25, 0, 1584, 510}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int exp_h, input int exp_v, input string rh, input string rv);
    int n;
    @(negedge clk); h_start = 1'b1; v_start = 1'b1;
    @(negedge clk); h_start = 1'b0; v_start = 1'b0;
    chk("R3 done cleared by start", {h_done, v_done}, 0);
    n = 0;
    while (!h_done && n < 40000) begin @(negedge clk); n++; end
    chk(rh, h_count, exp_h);
    n = 0;
    while (!v_done && n < 40000) begin @(negedge clk); n++; end
    chk(rv, v_count, exp_v);
    chk("R3 done set", {h_done, v_done}, 3);
  endtask

  // horizontal generator: one period per pass, parameters read at period start
  initial forever begin
    if (!hen) begin
      hs = hidle; @(negedge clk);
    end else begin
      int a;
      a = hwide ? 150 : hw;
      hwide = 0;
      hs = !hneg; wait_clk(a);
      hs = hneg;  wait_clk(hp - hw);
    end
  end

  initial forever begin
    if (!ven) begin
      vs = vidle; @(negedge clk);
    end else begin
      vs = !vneg; wait_clk(vw);
      vs = vneg;  wait_clk(vp - vw);
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    // R11 reset state
    chk("R11 done flags", {h_done, v_done}, 0);
    chk("R11 counts", h_count + v_count, 0);
    chk("R11 presence", {h_pre, v_pre, hv_pre}, 0);
    chk("R11 mode off", mode, 3);

    for (int r = 0; r < ROWS; r++) begin
      hp = TBL[r][0]; hw = TBL[r][1]; hneg = TBL[r][2] != 0;
      vp = TBL[r][3]; vw = TBL[r][4]; vneg = TBL[r][5] != 0;
      hen = 1; ven = 1;
      wait_clk(3 * vp);
      measure(TBL[r][6], TBL[r][7], "R1 h count", "R2 v count");
      chk("R7 h auto polarity", h_pol, TBL[r][2] == 0);
      chk("R7 v auto polarity", v_pol, TBL[r][5] == 0);
      chk("R5 both present", {h_pre, v_pre}, 3);
      chk("R6 separate mode", mode, 0);
      chk("R10 no composite", hv_pre, 0);
    end

    // R3: finished result holds
    wait_clk(500);
    chk("R3 h result held", h_count, 1584);
    chk("R3 h done held", h_done, 1);

    // R8 polarity overrides (horizontal negative, vertical positive now)
    h_force = 2'b01; wait_clk(3); chk("R8 h force 01", h_pol, 1);
    h_force = 2'b10; wait_clk(3); chk("R8 h force 10", h_pol, 0);
    h_force = 2'b11; wait_clk(3); chk("R8 h force 11 auto", h_pol, 0);
    v_force = 2'b10; wait_clk(3); chk("R8 v force 10", v_pol, 0);
    v_force = 2'b00; wait_clk(3); chk("R8 v force 00 auto", v_pol, 1);
    h_force = 2'b00;

    // R10 composite: one over-long high phase on a positive line
    hp = 40; hw = 4; hneg = 0;
    wait_clk(400);
    hwide = 1;
    wait_clk(400);
    chk("R10 composite seen", hv_pre, 1);
    chk("R10 polarity kept", h_pol, 1);
    chk("R6 separate with composite", mode, 0);
    wait_clk(COMP_TMO + 300);
    chk("R10 composite timed out", hv_pre, 0);

    // R5/R9/R6 suspend: horizontal stops high
    hidle = 1; hen = 0;
    wait_clk(H_TMO + 60);
    chk("R5 h absent", h_pre, 0);
    chk("R9 h rest high", h_lvl, 1);
    chk("R6 suspend mode", mode, 2);
    hidle = 0;
    wait_clk(H_TMO + 60);
    chk("R9 h rest low", h_lvl, 0);

    // R6 off: vertical stops low
    vidle = 0; ven = 0;
    wait_clk(V_TMO + 100);
    chk("R5 v absent", v_pre, 0);
    chk("R9 v rest low", v_lvl, 0);
    chk("R6 off mode", mode, 3);

    // R6 composite mode: only horizontal toggling
    hen = 1;
    wait_clk(500);
    chk("R6 horizontal only mode", mode, 1);

    // R4 saturation on both axes
    hp = 200; hw = 4; hneg = 0;
    vp = 5000; vw = 20; vneg = 0; ven = 1;
    wait_clk(2 * vp);
    measure(2047, 511, "R4 h saturates", "R4 v saturates");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule